// File: doc/BRIEF.md
# Queued SPI Master Controller

This block is an SPI master that runs a short list of byte transfers on its own. Software first fills three small internal memories through a pointer/data register pair: one holds a 16-bit command word per entry, one the byte to send, and one collects the byte received. It then sets the last entry index and writes the start bit. The controller steps through the entries from index 0 to that last index without further help. For each entry it drives the serial clock and the data out line, samples the data in line, and drives the chip-select lines named in the command word. When the last entry has been stored it sets a completion flag and clears the start bit.

The clock polarity, the sampling phase and the baud divisor come from a mode register. A bit in the wrap register sets the level of the chip-select lines when they are inactive. Per-entry command bits choose whether chip select stays asserted into the next entry and whether a fixed pause follows the transfer.

Top module: `qspi_master`

Register map (`reg_addr`): 0 mode, 1 control, 2 wrap, 3 flag, 4 pointer, 5 data.

## Requirements
- R1: Data-register accesses reach the memory selected by pointer bits [5:4]: 0 = transmit, 1 = receive, 2 = command, with the entry index in bits [3:0]. Every data read or write advances the pointer by one. Writes into the receive region are ignored.
- R2: After a start, entries 0 through the last index in wrap bits [3:0] run in ascending order, exactly once each. A last index of 15 runs all 16 entries.
- R3: Each entry shifts 8 bits MSB first with 16 clock edges, and the clock rests at mode bit 9 (polarity). With mode bit 8 (phase) = 0, data is captured on the first edge after chip select asserts, so the first and every odd-numbered edge capture. With phase = 1, the second and every even-numbered edge capture.
- R4: Each clock half period lasts D system cycles. D is mode bits [7:0], raised to 2 when the field is below 2.
- R5: The byte received by entry i is stored at receive index i.
- R6: Writing control bit 15 as 1 starts the queue. That bit reads back 1 while the queue runs and clears itself at completion. Flag bit 0 sets at completion and holds. It clears only on a write with bit 0 = 1; a write with bit 0 = 0 leaves it set.
- R7: Command bits [3:0] pick the chip selects of an entry. The inactive level is wrap bit 7, and active is its inverse. With command bit 15 = 1, chip select stays asserted into the next entry; with it 0, chip select is released between entries. All lines are inactive once the queue completes.
- R8: Command bit 13 = 1 adds DELAY_CYCLES system cycles after that entry's transfer, with chip select still asserted.
- R9: A start write while mode bit 15 (master enable) is 0 is ignored: no clock edge, no chip select, and no flag.
- R10: After reset the clock is low, all chip selects are high, mode, control and flag read 0, and wrap reads 0x0080.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_en | input | 1 | Register access strobe, one cycle per access |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from reg_addr |
| spi_sck | output | 1 | Serial clock |
| spi_sout | output | 1 | Serial data out |
| spi_sin | input | 1 | Serial data in |
| spi_cs | output | 4 | Chip-select lines |

## Verification
The bench builds the block with DEPTH = 16, so a full queue of sixteen entries can be run end to end. It sets DELAY_CYCLES = 6, which makes the pause easy to measure: two otherwise identical runs, one with the delay bit set and one without, must differ by exactly twelve cycles of chip-select activity. A behavioural slave on the pins answers with its own byte sequence and logs the bytes it captures. This exposes wrong capture edges, wrong bit order and wrong receive indexing under all four polarity and phase combinations. The divisor values 0, 1, 2, 3, 5 and 255 cover the clamp and the slowest clock.

// File: rtl/qspi_pkg.sv
package qspi_pkg;
  localparam int CMD_W = 16;
  localparam int CS_N  = 4;

  localparam logic [2:0] RA_MODE = 3'd0;
  localparam logic [2:0] RA_CTRL = 3'd1;
  localparam logic [2:0] RA_WRAP = 3'd2;
  localparam logic [2:0] RA_FLAG = 3'd3;
  localparam logic [2:0] RA_PTR  = 3'd4;
  localparam logic [2:0] RA_DATA = 3'd5;

  localparam logic [1:0] RG_TX  = 2'd0;
  localparam logic [1:0] RG_RX  = 2'd1;
  localparam logic [1:0] RG_CMD = 2'd2;

  localparam int MB_EN   = 15;
  localparam int MB_CPOL = 9;
  localparam int MB_CPHA = 8;
  localparam int WB_IDLE = 7;

  typedef struct packed {
    logic       cont;
    logic       bitse;
    logic       dt;
    logic [8:0] rsvd;
    logic [3:0] sel;
  } cmd_t;

  // Divisor floor: the fastest legal setting is 2.
  function automatic logic [7:0] clamp_div(input logic [7:0] raw);
    return (raw < 8'd2) ? 8'd2 : raw;
  endfunction

  // odd = edge index is odd (trailing edge); index counts from 0.
  function automatic logic is_sample_edge(input logic cpha, input logic odd);
    return cpha ? odd : !odd;
  endfunction

  function automatic logic is_shift_edge(input logic cpha, input logic odd,
                                         input logic first);
    return cpha ? (!odd && !first) : odd;
  endfunction
endpackage

// File: rtl/qspi_clkdiv.sv
module qspi_clkdiv #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [DW-1:0] div,
  output logic          tick
);
  logic [DW-1:0] cnt;

  assign tick = run && (cnt == div - DW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                 cnt <= cnt + DW'(1);
  end

  // Divisor never below 2, so two edges never fall in adjacent cycles.
  assert_no_back2back_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/qspi_shift.sv
module qspi_shift import qspi_pkg::*; #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cpol,
  input  logic            cpha,
  input  logic            load,
  input  logic            run,
  input  logic            tick,
  input  logic [BITS-1:0] tx_byte,
  input  logic            sin,
  output logic            sck,
  output logic            sout,
  output logic [BITS-1:0] rx_byte,
  output logic            xfer_done
);
  localparam int EDGES = 2 * BITS;
  localparam int EW    = $clog2(EDGES);

  logic [BITS-1:0] tx_sh, rx_sh;
  logic [EW-1:0]   ecnt;
  logic            edge_now, odd_edge, first_edge;

  assign edge_now   = run && tick;
  assign odd_edge   = ecnt[0];
  assign first_edge = (ecnt == '0);
  assign xfer_done  = edge_now && (ecnt == EW'(EDGES - 1));
  assign sout       = tx_sh[BITS-1];
  assign rx_byte    = rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck   <= 1'b0;
      tx_sh <= '0;
      rx_sh <= '0;
      ecnt  <= '0;
    end else if (load) begin
      tx_sh <= tx_byte;
      ecnt  <= '0;
      sck   <= cpol;
    end else if (edge_now) begin
      sck  <= ~sck;
      ecnt <= ecnt + EW'(1);
      if (is_sample_edge(cpha, odd_edge))
        rx_sh <= {rx_sh[BITS-2:0], sin};
      if (is_shift_edge(cpha, odd_edge, first_edge))
        tx_sh <= {tx_sh[BITS-2:0], 1'b0};
    end else if (!run) begin
      sck <= cpol;
    end
  end
endmodule

// File: rtl/qspi_seq.sv
module qspi_seq import qspi_pkg::*; #(
  parameter int IDX_W        = 4,
  parameter int DELAY_CYCLES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IDX_W-1:0] end_idx,
  input  logic [CMD_W-1:0] cmd_word,
  input  logic             xfer_done,
  output logic [IDX_W-1:0] idx,
  output logic             load,
  output logic             run,
  output logic             store,
  output logic             finish,
  output logic             busy,
  output logic [CS_N-1:0]  cs_mask
);
  localparam int DLY_W = $clog2(DELAY_CYCLES + 1);

  typedef enum logic [2:0] {SQ_IDLE, SQ_SETUP, SQ_XFER, SQ_STORE, SQ_DELAY, SQ_GAP} sq_t;

  sq_t             st;
  logic [DLY_W-1:0] dly;
  cmd_t            cmd;
  logic            dly_last, entry_end, at_end;

  assign cmd       = cmd_t'(cmd_word);
  assign dly_last  = (st == SQ_DELAY) && (dly == DLY_W'(DELAY_CYCLES - 1));
  assign entry_end = ((st == SQ_STORE) && !cmd.dt) || dly_last;
  assign at_end    = (idx == end_idx);
  assign finish    = entry_end && at_end;
  assign load      = (st == SQ_SETUP);
  assign run       = (st == SQ_XFER);
  assign store     = (st == SQ_STORE);
  assign busy      = (st != SQ_IDLE);

  always_comb begin
    case (st)
      SQ_IDLE: cs_mask = '0;
      SQ_GAP:  cs_mask = cmd.cont ? cmd.sel : '0;
      default: cs_mask = cmd.sel;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= SQ_IDLE;
      idx <= '0;
      dly <= '0;
    end else begin
      case (st)
        SQ_IDLE:  if (start) begin idx <= '0; st <= SQ_SETUP; end
        SQ_SETUP: st <= SQ_XFER;
        SQ_XFER:  if (xfer_done) st <= SQ_STORE;
        SQ_STORE: begin
          if (cmd.dt) begin dly <= '0; st <= SQ_DELAY; end
          else if (at_end) st <= SQ_IDLE;
          else st <= SQ_GAP;
        end
        SQ_DELAY: begin
          dly <= dly + DLY_W'(1);
          if (dly_last) st <= at_end ? SQ_IDLE : SQ_GAP;
        end
        SQ_GAP: begin
          idx <= idx + IDX_W'(1);
          st  <= SQ_SETUP;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assert_idx_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (idx <= end_idx));
endmodule

// File: rtl/qspi_master.sv
module qspi_master import qspi_pkg::*; #(
  parameter int DEPTH        = 16,
  parameter int DELAY_CYCLES = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_en,
  input  logic            reg_we,
  input  logic [2:0]      reg_addr,
  input  logic [15:0]     reg_wdata,
  output logic [15:0]     reg_rdata,
  output logic            spi_sck,
  output logic            spi_sout,
  input  logic            spi_sin,
  output logic [CS_N-1:0] spi_cs
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [15:0]      mode_q;
  logic             go_q, idle_q, done_q;
  logic [IDX_W-1:0] end_q;
  logic [5:0]       ptr_q;

  logic [CMD_W-1:0] cmd_mem [DEPTH];
  logic [7:0]       tx_mem  [DEPTH];
  logic [7:0]       rx_mem  [DEPTH];

  logic             wr_hit, data_hit, start_pulse, flag_clr;
  logic [1:0]       region;
  logic [IDX_W-1:0] slot;

  logic [IDX_W-1:0] seq_idx;
  logic             seq_load, seq_run, seq_store, seq_finish, seq_busy;
  logic [CS_N-1:0]  seq_mask;
  logic             div_tick, xfer_done;
  logic [7:0]       rx_byte, div_eff;

  assign wr_hit      = reg_en && reg_we;
  assign data_hit    = reg_en && (reg_addr == RA_DATA);
  assign region      = ptr_q[5:4];
  assign slot        = ptr_q[IDX_W-1:0];
  assign start_pulse = wr_hit && (reg_addr == RA_CTRL) && reg_wdata[15]
                       && mode_q[MB_EN] && !go_q;
  assign flag_clr    = wr_hit && (reg_addr == RA_FLAG) && reg_wdata[0];
  assign div_eff     = clamp_div(mode_q[7:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      go_q   <= 1'b0;
      idle_q <= 1'b1;
      done_q <= 1'b0;
      end_q  <= '0;
      ptr_q  <= '0;
    end else begin
      if (wr_hit && reg_addr == RA_MODE) mode_q <= reg_wdata;
      if (wr_hit && reg_addr == RA_WRAP) begin
        idle_q <= reg_wdata[WB_IDLE];
        end_q  <= reg_wdata[IDX_W-1:0];
      end
      if (wr_hit && reg_addr == RA_PTR) ptr_q <= reg_wdata[5:0];
      else if (data_hit)                ptr_q <= ptr_q + 6'd1;
      if (start_pulse)     go_q <= 1'b1;
      else if (seq_finish) go_q <= 1'b0;
      if (seq_finish)    done_q <= 1'b1;
      else if (flag_clr) done_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_hit && reg_addr == RA_DATA) begin
      if (region == RG_TX)       tx_mem[slot]  <= reg_wdata[7:0];
      else if (region == RG_CMD) cmd_mem[slot] <= reg_wdata;
    end
    if (seq_store) rx_mem[seq_idx] <= rx_byte;
  end

  always_comb begin
    case (reg_addr)
      RA_MODE: reg_rdata = mode_q;
      RA_CTRL: reg_rdata = {go_q, 15'd0};
      RA_WRAP: reg_rdata = 16'({idle_q, 3'd0, 4'(end_q)});
      RA_FLAG: reg_rdata = {15'd0, done_q};
      RA_PTR:  reg_rdata = {10'd0, ptr_q};
      RA_DATA: begin
        case (region)
          RG_TX:   reg_rdata = {8'd0, tx_mem[slot]};
          RG_RX:   reg_rdata = {8'd0, rx_mem[slot]};
          RG_CMD:  reg_rdata = cmd_mem[slot];
          default: reg_rdata = '0;
        endcase
      end
      default: reg_rdata = '0;
    endcase
  end

  assign spi_cs = {CS_N{idle_q}} ^ seq_mask;

  qspi_seq #(.IDX_W(IDX_W), .DELAY_CYCLES(DELAY_CYCLES)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start_pulse), .end_idx(end_q),
    .cmd_word(cmd_mem[seq_idx]), .xfer_done(xfer_done), .idx(seq_idx),
    .load(seq_load), .run(seq_run), .store(seq_store), .finish(seq_finish),
    .busy(seq_busy), .cs_mask(seq_mask)
  );

  qspi_clkdiv #(.DW(8)) div_i (
    .clk(clk), .rst_n(rst_n), .run(seq_run), .div(div_eff), .tick(div_tick)
  );

  qspi_shift #(.BITS(8)) shift_i (
    .clk(clk), .rst_n(rst_n), .cpol(mode_q[MB_CPOL]), .cpha(mode_q[MB_CPHA]),
    .load(seq_load), .run(seq_run), .tick(div_tick), .tx_byte(tx_mem[seq_idx]),
    .sin(spi_sin), .sck(spi_sck), .sout(spi_sout), .rx_byte(rx_byte),
    .xfer_done(xfer_done)
  );

  assert_go_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    seq_finish |=> !go_q);
  assert_done_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !flag_clr) |=> done_q);
  assert_cs_idle_after_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> (spi_cs == {CS_N{idle_q}}));
  assert_sck_rest_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(seq_busy) |-> (spi_sck == mode_q[MB_CPOL]));
endmodule

// File: tb/qspi_master_tb_top.sv
`timescale 1ns/1ps
module qspi_master_tb_top;
  localparam int DLY = 6;
  localparam int NV  = 7;

  typedef struct packed {
    logic       cpol;
    logic       cpha;
    logic [7:0] baud;
    logic [4:0] n;
    logic [3:0] mask;
    logic       cont;
    logic       idle;
    logic       dt;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 8'd2,   5'd1,  4'b0001, 1'b1, 1'b1, 1'b0},
    '{1'b1, 1'b0, 8'd3,   5'd4,  4'b0010, 1'b0, 1'b1, 1'b0},
    '{1'b0, 1'b1, 8'd5,   5'd16, 4'b0100, 1'b1, 1'b1, 1'b0},
    '{1'b1, 1'b1, 8'd2,   5'd3,  4'b1000, 1'b0, 1'b0, 1'b0},
    '{1'b0, 1'b0, 8'd0,   5'd2,  4'b0011, 1'b1, 1'b1, 1'b1},
    '{1'b1, 1'b1, 8'd255, 5'd1,  4'b0101, 1'b0, 1'b1, 1'b0},
    '{1'b0, 1'b0, 8'd1,   5'd2,  4'b0011, 1'b1, 1'b1, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_en = 1'b0, reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic spi_sck, spi_sout, spi_sin;
  logic [3:0] spi_cs;

  always #2 clk = ~clk;

  qspi_master #(.DEPTH(16), .DELAY_CYCLES(DLY)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .spi_sck(spi_sck), .spi_sout(spi_sout), .spi_sin(spi_sin), .spi_cs(spi_cs)
  );

  int checks = 0, fails = 0;
  bit done_flag = 0;

  function automatic logic [7:0] reply_byte(int k);
    return 8'((k * 29 + 7) & 255);
  endfunction
  function automatic logic [7:0] tx_val(int v, int i);
    return 8'((v * 53 + i * 17 + 165) & 255);
  endfunction

  // Behavioural slave and pin monitor
  bit mon = 0, cur_cpol = 0, cur_cpha = 0, cur_idle = 1, prev_act = 0;
  int byte_n = 0, bitcnt = 0, edges = 0, releases = 0, sck_any = 0;
  longint min_half, last_edge_t, first_t, last_t;
  logic [7:0] sh = '0;
  logic [7:0] mosi_log [16];
  logic [3:0] cs_log [16];
  logic [7:0] miso_byte;

  assign miso_byte = reply_byte(byte_n);
  assign spi_sin   = miso_byte[3'(7 - bitcnt)];

  always @(spi_sck) begin
    sck_any++;
    if (mon && spi_cs != {4{cur_idle}}) begin
      bit lead;
      edges++;
      if (last_edge_t >= 0 && ($time - last_edge_t) < min_half) min_half = $time - last_edge_t;
      last_edge_t = $time;
      lead = (spi_sck != cur_cpol);
      if (cur_cpha ? !lead : lead) begin
        sh = {sh[6:0], spi_sout};
        bitcnt++;
        if (bitcnt == 8) begin
          if (byte_n < 16) begin mosi_log[byte_n] = sh; cs_log[byte_n] = spi_cs; end
          byte_n++;
          bitcnt = 0;
        end
      end
    end
  end

  always @(spi_cs) begin
    if (mon) begin
      bit now_act;
      now_act = (spi_cs != {4{cur_idle}});
      if (now_act && !prev_act && first_t < 0) first_t = $time;
      if (!now_act && prev_act) begin releases++; last_t = $time; end
      prev_act = now_act;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_en = 1'b0;
  endtask

  longint span [NV];

  task automatic run_vec(input int vi);
    vec_t v;
    logic [15:0] d;
    int guard;
    v = VECS[vi];
    wr(3'd0, {1'b1, 1'b0, 4'd8, v.cpol, v.cpha, v.baud});
    wr(3'd2, {8'd0, v.idle, 3'd0, 4'(v.n - 5'd1)});
    wr(3'd4, 16'h0020);
    for (int i = 0; i < int'(v.n); i++) wr(3'd5, {v.cont, 1'b1, v.dt, 9'd0, v.mask});
    wr(3'd4, 16'h0000);
    for (int i = 0; i < int'(v.n); i++) wr(3'd5, {8'd0, tx_val(vi, i)});
    cur_cpol = v.cpol; cur_cpha = v.cpha; cur_idle = v.idle;
    byte_n = 0; bitcnt = 0; edges = 0; releases = 0; prev_act = 0;
    min_half = 64'd1 << 40; last_edge_t = -1; first_t = -1; last_t = -1;
    mon = 1;
    wr(3'd1, 16'h8000);
    rd(3'd1, d);
    chk("R6 control bit reads 1 while running", d[15], 1);
    guard = 0;
    do begin rd(3'd3, d); guard++; end while (!d[0] && guard < 20000);
    mon = 0;
    chk("R6 completion flag", d[0], 1);
    rd(3'd1, d);
    chk("R6 start bit self-cleared", d[15], 0);
    chk("R7 chip selects idle after queue", spi_cs, {4{v.idle}});
    chk("R3 sck rests at polarity", spi_sck, v.cpol);
    chk("R2 entries run", byte_n, v.n);
    chk("R3 sixteen edges per entry", edges, 16 * int'(v.n));
    chk("R4 half period ns", min_half, 4 * int'((v.baud < 8'd2) ? 8'd2 : v.baud));
    chk("R7 releases", releases, v.cont ? 1 : int'(v.n));
    for (int i = 0; i < int'(v.n) && i < 16; i++) begin
      chk("R3 MSB-first byte seen by slave", mosi_log[i], tx_val(vi, i));
      chk("R7 chip select pattern", cs_log[i], {4{v.idle}} ^ v.mask);
    end
    wr(3'd4, 16'h0010);
    for (int i = 0; i < int'(v.n); i++) begin
      rd(3'd5, d);
      chk("R5 received byte at own index", d[7:0], reply_byte(i));
    end
    span[vi] = last_t - first_t;
    wr(3'd3, 16'h0001);
  endtask

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 sck after reset", spi_sck, 0);
    chk("R10 chip selects after reset", spi_cs, 4'hF);
    rd(3'd0, d); chk("R10 mode", d, 0);
    rd(3'd1, d); chk("R10 control", d, 0);
    rd(3'd3, d); chk("R10 flag", d, 0);
    rd(3'd2, d); chk("R10 wrap", d, 16'h0080);

    // R1 pointer regions and auto-increment
    wr(3'd4, 16'h0000);
    wr(3'd5, 16'h0011); wr(3'd5, 16'h0022); wr(3'd5, 16'h0033);
    rd(3'd4, d); chk("R1 pointer after three writes", d, 3);
    wr(3'd4, 16'h0000);
    rd(3'd5, d); chk("R1 tx entry 0", d, 16'h11);
    rd(3'd5, d); chk("R1 tx entry 1", d, 16'h22);
    rd(3'd5, d); chk("R1 tx entry 2", d, 16'h33);
    wr(3'd4, 16'h002F); wr(3'd5, 16'hA00F);
    wr(3'd4, 16'h002F); rd(3'd5, d); chk("R1 command entry 15", d, 16'hA00F);

    for (int vi = 0; vi < NV; vi++) run_vec(vi);

    // R8: vector 4 has the delay bit, vector 6 is otherwise alike
    chk("R8 delay adds cycles", span[4] - span[6], 2 * DLY * 4);

    // R1: receive region writes ignored
    wr(3'd4, 16'h0010); rd(3'd5, d);
    wr(3'd4, 16'h0010); wr(3'd5, 16'h005A);
    rd(3'd4, d); chk("R1 pointer advanced by data write", d, 16'h11);
    wr(3'd4, 16'h0010); rd(3'd5, d);
    chk("R1 receive write ignored", d[7:0], reply_byte(0));

    // R6: writing 0 to flag keeps it, writing 1 clears it
    wr(3'd0, {1'b1, 1'b0, 4'd8, 1'b0, 1'b0, 8'd2});
    wr(3'd2, 16'h0080);
    wr(3'd1, 16'h8000);
    repeat (60) @(negedge clk);
    wr(3'd3, 16'h0000); rd(3'd3, d); chk("R6 flag kept on zero write", d[0], 1);
    wr(3'd3, 16'h0001); rd(3'd3, d); chk("R6 flag cleared on one write", d[0], 0);

    // R9: start ignored without master enable
    wr(3'd0, {1'b0, 1'b0, 4'd8, 1'b0, 1'b0, 8'd2});
    sck_any = 0;
    wr(3'd1, 16'h8000);
    repeat (60) @(negedge clk);
    chk("R9 no clock edges", sck_any, 0);
    chk("R9 chip selects idle", spi_cs, 4'hF);
    rd(3'd3, d); chk("R9 flag stays clear", d[0], 0);
    rd(3'd1, d); chk("R9 control stays clear", d[15], 0);

    done_flag = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 190000 && !done_flag) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", wd);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule